// File: doc/BRIEF.md
# Bit-Copy-and-Jump Sequencer Core

This block is a minimal processor whose only operation moves a single bit and then jumps. Its storage is an internal array of bits grouped into words of `WORD_W` bits; every operand is a full word that holds a bit address. An instruction occupies three consecutive words: a source bit address, a destination bit address and a jump target. The core fetches the three operands starting at its program counter, reads the source bit, writes it into the destination bit with a read-modify-write of the containing word, and loads the program counter from the jump target. Wider values are moved by issuing one instruction per bit position. Conditional flow is built in software: a program copies data bits into the jump-target operands of instructions that have not yet executed.

A bit address splits into a word index (upper `WORD_W - log2(WORD_W)` bits) and a bit position (lower `log2(WORD_W)` bits, position 0 being the least significant bit of the word). With the default `WORD_W = 8`, the store holds 32 words, 256 bits. The environment fills the store through a word-wide load port while the core is idle, pulses `start`, and waits for `halted`. Any word can be read back combinationally through a peek port.

The sequencer has seven states. IDLE (after reset) and HALT wait for `start`, which clears the program counter and moves to FETCH_A. FETCH_A, FETCH_B and FETCH_C each latch one operand from word `pc`, `pc+1` and `pc+2` (modulo the store size) and always advance in that order. FETCH_C goes to READ, which latches the source bit. READ goes to WRITE, which performs the bit write and the jump. WRITE goes to HALT when the jump target word equals the current instruction's word and to FETCH_A otherwise.

Top module: `bcj_core`

## Requirements
- R1: After reset `halted` is 0 and every word of the store reads 0 through the peek port.
- R2: While the core is idle or halted, a cycle with `ld_we` high writes `ld_data` into word `ld_idx`, and `peek_data` shows word `peek_idx` in the same cycle without a clock edge.
- R3: An instruction copies the bit at its source address into the bit at its destination address (word index in the upper bits, bit position in the lower log2(WORD_W) bits, position 0 is the LSB), for both a 1 and a 0 value, leaving the other bits of the destination word unchanged.
- R4: After the copy, execution continues at the word index held in the upper bits of the jump operand; its lower log2(WORD_W) bits are ignored, and instructions not on the path are not executed.
- R5: When the jump target word equals the current instruction's first word, the copy still takes effect, `halted` rises and stays high until `start` is seen; a new `start` reruns the program from word 0.
- R6: A source and destination in the same word behave as for distinct words: the written word holds the source bit value at the destination position and all its previous other bits.
- R7: Operands are fetched after the preceding instruction's write, so a bit copied into a later instruction's jump operand changes where that instruction jumps.
- R8: Each instruction takes exactly five cycles (FETCH_A, FETCH_B, FETCH_C, READ, WRITE in order), so `halted` is high five clock edges per executed instruction after the edge that sampled `start`.
- R9: While the core is running, `ld_we` and `start` have no effect: the store word addressed by the load keeps its value and the run length is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution at word 0 when idle or halted |
| ld_we | input | 1 | Load one word of the store (ignored while running) |
| ld_idx | input | WORD_W-log2(WORD_W) | Word index for the load |
| ld_data | input | WORD_W | Word value to load |
| peek_idx | input | WORD_W-log2(WORD_W) | Word index to observe |
| peek_data | output | WORD_W | Current content of word `peek_idx` |
| halted | output | 1 | High once a self-jump has executed |

## Verification
A wrong bit position or word split in the decoder shows as a wrong bit, or a clobbered neighbour bit, in the destination word read back once the program halts. A sequencer that skips or repeats a state shows immediately as a run length that is not five cycles per instruction, measured from `start` to `halted`. A wrong jump decode or a stale operand shows as a marker bit written by an instruction off the intended path, or as a missing or late halt, within one instruction time. Self-modifying programs are run with both values of the steering bit so that each taken path leaves its own marker.

// File: rtl/bcj_pkg.sv
package bcj_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_FETCH_A = 3'd1,
        ST_FETCH_B = 3'd2,
        ST_FETCH_C = 3'd3,
        ST_READ    = 3'd4,
        ST_WRITE   = 3'd5,
        ST_HALT    = 3'd6
    } seq_state_t;

endpackage

// File: rtl/bcj_bitmem.sv
module bcj_bitmem #(
    parameter int WORD_W = 8,
    parameter int N_RD   = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [IDX_W-1:0]               widx,
    input  logic [WORD_W-1:0]              wdata,
    input  logic [N_RD-1:0][IDX_W-1:0]     rd_idx,
    output logic [N_RD-1:0][WORD_W-1:0]    rd_data
);
    localparam int POS_W = $clog2(WORD_W);
    localparam int IDX_W = WORD_W - POS_W;
    localparam int WORDS = 1 << IDX_W;

    logic [WORD_W-1:0] store [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                store[i] <= '0;
            end
        end else if (we) begin
            store[widx] <= wdata;
        end
    end

    for (genvar g = 0; g < N_RD; g++) begin : g_rd
        assign rd_data[g] = store[rd_idx[g]];
    end

endmodule

// File: rtl/bcj_bit_merge.sv
module bcj_bit_merge #(
    parameter int WORD_W = 8
) (
    input  logic [WORD_W-1:0]              word_in,
    input  logic [$clog2(WORD_W)-1:0]      pos,
    input  logic                           bit_val,
    output logic [WORD_W-1:0]              word_out
);
    always_comb begin
        for (int i = 0; i < WORD_W; i++) begin
            word_out[i] = (pos == i[$clog2(WORD_W)-1:0]) ? bit_val : word_in[i];
        end
    end

endmodule

// File: rtl/bcj_seq.sv
module bcj_seq
    import bcj_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic [IDX_W-1:0]      fetch_idx,
    input  logic [WORD_W-1:0]     fetch_word,
    output logic [IDX_W-1:0]      dst_idx,
    input  logic [WORD_W-1:0]     dst_word,
    output logic                  we,
    output logic [WORD_W-1:0]     wdata,
    output logic                  busy,
    output logic                  halted,
    output seq_state_t            state_o,
    output logic [IDX_W-1:0]      pc_o,
    output logic [IDX_W-1:0]      jump_o
);
    localparam int POS_W = $clog2(WORD_W);
    localparam int IDX_W = WORD_W - POS_W;

    seq_state_t        state, state_nx;
    logic [IDX_W-1:0]  pc;
    logic [WORD_W-1:0] op_src, op_dst, op_jmp;
    logic              src_bit;
    logic [IDX_W-1:0]  jmp_idx;

    assign jmp_idx = op_jmp[WORD_W-1:POS_W];
    assign dst_idx = op_dst[WORD_W-1:POS_W];

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_HALT: if (start) state_nx = ST_FETCH_A;
            ST_FETCH_A:       state_nx = ST_FETCH_B;
            ST_FETCH_B:       state_nx = ST_FETCH_C;
            ST_FETCH_C:       state_nx = ST_READ;
            ST_READ:          state_nx = ST_WRITE;
            ST_WRITE:         state_nx = (jmp_idx == pc) ? ST_HALT : ST_FETCH_A;
            default:          state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // operand and program-counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc      <= '0;
            op_src  <= '0;
            op_dst  <= '0;
            op_jmp  <= '0;
            src_bit <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_HALT: if (start) pc <= '0;
                ST_FETCH_A:       op_src  <= fetch_word;
                ST_FETCH_B:       op_dst  <= fetch_word;
                ST_FETCH_C:       op_jmp  <= fetch_word;
                ST_READ:          src_bit <= fetch_word[op_src[POS_W-1:0]];
                ST_WRITE:         pc      <= jmp_idx;
                default:          pc      <= pc;
            endcase
        end
    end

    // outputs per state
    always_comb begin
        fetch_idx = pc;
        we        = 1'b0;
        busy      = 1'b1;
        halted    = 1'b0;
        unique case (state)
            ST_IDLE:    busy = 1'b0;
            ST_HALT:    begin busy = 1'b0; halted = 1'b1; end
            ST_FETCH_A: fetch_idx = pc;
            ST_FETCH_B: fetch_idx = IDX_W'(pc + 1'b1);
            ST_FETCH_C: fetch_idx = IDX_W'(pc + 2'd2);
            ST_READ:    fetch_idx = op_src[WORD_W-1:POS_W];
            ST_WRITE:   we = 1'b1;
            default:    busy = 1'b0;
        endcase
    end

    bcj_bit_merge #(.WORD_W(WORD_W)) u_merge (
        .word_in  (dst_word),
        .pos      (op_dst[POS_W-1:0]),
        .bit_val  (src_bit),
        .word_out (wdata)
    );

    assign state_o = state;
    assign pc_o    = pc;
    assign jump_o  = jmp_idx;

endmodule

// File: rtl/bcj_core.sv
module bcj_core
    import bcj_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic                                   ld_we,
    input  logic [WORD_W-$clog2(WORD_W)-1:0]       ld_idx,
    input  logic [WORD_W-1:0]                      ld_data,
    input  logic [WORD_W-$clog2(WORD_W)-1:0]       peek_idx,
    output logic [WORD_W-1:0]                      peek_data,
    output logic                                   halted
);
    localparam int POS_W = $clog2(WORD_W);
    localparam int IDX_W = WORD_W - POS_W;
    localparam int N_RD  = 3;

    logic [IDX_W-1:0]             fetch_idx, dst_idx, cur_pc, cur_jump;
    logic [WORD_W-1:0]            core_wdata;
    logic                         core_we, busy;
    seq_state_t                   cur_state;
    logic [N_RD-1:0][IDX_W-1:0]   rd_idx;
    logic [N_RD-1:0][WORD_W-1:0]  rd_data;
    logic                         mem_we;
    logic [IDX_W-1:0]             mem_widx;
    logic [WORD_W-1:0]            mem_wdata;

    assign rd_idx[0] = fetch_idx;
    assign rd_idx[1] = dst_idx;
    assign rd_idx[2] = peek_idx;
    assign peek_data = rd_data[2];

    // core write wins; external load only while not running
    always_comb begin
        mem_we    = core_we | (ld_we & ~busy);
        mem_widx  = core_we ? dst_idx : ld_idx;
        mem_wdata = core_we ? core_wdata : ld_data;
    end

    bcj_bitmem #(.WORD_W(WORD_W), .N_RD(N_RD)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .widx    (mem_widx),
        .wdata   (mem_wdata),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    bcj_seq #(.WORD_W(WORD_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .fetch_idx  (fetch_idx),
        .fetch_word (rd_data[0]),
        .dst_idx    (dst_idx),
        .dst_word   (rd_data[1]),
        .we         (core_we),
        .wdata      (core_wdata),
        .busy       (busy),
        .halted     (halted),
        .state_o    (cur_state),
        .pc_o       (cur_pc),
        .jump_o     (cur_jump)
    );

endmodule

// File: rtl/bcj_core_chk.sv
module bcj_core_chk
    import bcj_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             halted,
    input seq_state_t       cur_state,
    input logic [IDX_W-1:0] cur_pc,
    input logic [IDX_W-1:0] cur_jump
);
    AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        cur_state == ST_FETCH_A |=> cur_state == ST_FETCH_B); // R8
    AST_OPERAND_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cur_state == ST_FETCH_C |=> cur_state == ST_READ); // R8
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        cur_state == ST_WRITE |=> cur_pc == $past(cur_jump)); // R4
    AST_HALT_SELF_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> cur_pc == $past(cur_pc)); // R5
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        halted && !start |=> halted); // R5

endmodule

bind bcj_core bcj_core_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .halted    (halted),
    .cur_state (cur_state),
    .cur_pc    (cur_pc),
    .cur_jump  (cur_jump)
);

// File: tb/sim_bcj_core.sv
module sim_bcj_core;
    localparam int W     = 8;
    localparam int IDX_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             ld_we = 1'b0;
    logic [IDX_W-1:0] ld_idx = '0;
    logic [W-1:0]     ld_data = '0;
    logic [IDX_W-1:0] peek_idx = '0;
    logic [W-1:0]     peek_data;
    logic             halted;

    int tests = 0;
    int fails = 0;
    int n;

    int           q_idx[$];
    logic [W-1:0] q_val[$];
    string        q_tag[$];
    event         drain_ev;
    bit           drained;

    always #10 clk = ~clk;

    bcj_core #(.WORD_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ld_we(ld_we),
        .ld_idx(ld_idx), .ld_data(ld_data), .peek_idx(peek_idx),
        .peek_data(peek_data), .halted(halted)
    );

    function automatic logic [W-1:0] ba(input int word, input int pos);
        return W'(word * W + pos);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load(input int idx, input logic [W-1:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_idx = IDX_W'(idx); ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic put_instr(input int idx, input logic [W-1:0] a,
                             input logic [W-1:0] b, input logic [W-1:0] c);
        load(idx, a); load(idx + 1, b); load(idx + 2, c);
    endtask

    task automatic run(output int cycles);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 0;
        while (!halted && cycles < 1000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic expect_word(input int idx, input logic [W-1:0] v, input string tag);
        q_idx.push_back(idx); q_val.push_back(v); q_tag.push_back(tag);
    endtask

    task automatic drain();
        drained = 1'b0;
        -> drain_ev;
        wait (drained);
    endtask

    // monitor: compares store contents against queued expectations
    initial begin
        forever begin
            @(drain_ev);
            while (q_idx.size() > 0) begin
                int           i;
                logic [W-1:0] v;
                string        t;
                i = q_idx.pop_front(); v = q_val.pop_front(); t = q_tag.pop_front();
                peek_idx = IDX_W'(i);
                #1;
                check(peek_data === v, t, int'(peek_data), int'(v));
            end
            drained = 1'b1;
        end
    end

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R2: load and peek
        load(30, 8'h5A);
        load(2, 8'hC3);
        expect_word(30, 8'h5A, "R2 load word 30");
        expect_word(2, 8'hC3, "R2 load word 2");
        drain();

        // R1: reset clears store and halted
        do_reset();
        check(halted == 1'b0, "R1 halted after reset", int'(halted), 0);
        expect_word(30, 8'h00, "R1 word 30 cleared");
        expect_word(2, 8'h00, "R1 word 2 cleared");
        expect_word(31, 8'h00, "R1 word 31 cleared");
        drain();

        // R3 copy a one, R5 self jump, R8 timing
        put_instr(0, ba(10, 3), ba(11, 6), ba(0, 0));
        load(10, 8'h08); load(11, 8'h81);
        run(n);
        check(n == 5, "R8 one instruction cycles", n, 5);
        check(halted == 1'b1, "R5 halted after self jump", int'(halted), 1);
        expect_word(11, 8'hC1, "R3 copy one into bit 6");
        expect_word(10, 8'h08, "R3 source unchanged");
        drain();
        repeat (3) @(negedge clk);
        check(halted == 1'b1, "R5 halted holds", int'(halted), 1);
        load(11, 8'h00);
        run(n);
        check(n == 5, "R5 restart reruns", n, 5);
        expect_word(11, 8'h40, "R5 rerun copy");
        drain();

        // R3 copy a zero
        do_reset();
        put_instr(0, ba(10, 3), ba(11, 6), ba(0, 0));
        load(10, 8'hF7); load(11, 8'hFF);
        run(n);
        expect_word(11, 8'hBF, "R3 copy zero into bit 6");
        drain();

        // R4 jump decode, low bits ignored, skipped code not run
        do_reset();
        put_instr(0, ba(25, 0), ba(26, 0), ba(6, 5));
        put_instr(3, ba(25, 0), ba(20, 0), ba(3, 0));
        put_instr(6, ba(25, 0), ba(26, 1), ba(6, 0));
        load(25, 8'h01);
        run(n);
        check(n == 10, "R8 two instruction cycles", n, 10);
        expect_word(26, 8'h03, "R4 both path copies");
        expect_word(20, 8'h00, "R4 skipped instruction");
        drain();

        // R6 same-word source and destination
        do_reset();
        put_instr(0, ba(12, 1), ba(12, 7), ba(3, 0));
        put_instr(3, ba(13, 0), ba(13, 5), ba(3, 0));
        load(12, 8'h02); load(13, 8'hFE);
        run(n);
        expect_word(12, 8'h82, "R6 same word one");
        expect_word(13, 8'hDE, "R6 same word zero");
        drain();

        // R7 self-modifying branch, steering bit = 1 and 0
        for (int s = 0; s < 2; s++) begin
            do_reset();
            put_instr(0, ba(25, 2), ba(5, 6), ba(3, 0));
            put_instr(3, ba(25, 2), ba(21, 0), ba(6, 0));
            put_instr(6, ba(27, 0), ba(20, 0), ba(6, 0));
            put_instr(14, ba(27, 0), ba(20, 1), ba(14, 0));
            load(25, (s == 0) ? 8'h04 : 8'h00);
            load(27, 8'hFF);
            run(n);
            check(n == 15, "R7 path length", n, 15);
            expect_word(20, (s == 0) ? 8'h02 : 8'h01, "R7 taken path marker");
            expect_word(5, (s == 0) ? 8'h70 : 8'h30, "R7 modified jump operand");
            drain();
        end

        // R9 load and start ignored while running
        do_reset();
        put_instr(0, ba(25, 0), ba(26, 0), ba(3, 0));
        put_instr(3, ba(25, 0), ba(26, 1), ba(6, 0));
        put_instr(6, ba(25, 0), ba(26, 2), ba(6, 0));
        load(25, 8'h01);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        n = 1;
        ld_we = 1'b1; ld_idx = 5'd22; ld_data = 8'hAA; start = 1'b1;
        @(negedge clk);
        n = 2;
        ld_we = 1'b0; start = 1'b0;
        while (!halted && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(n == 15, "R9 run length unchanged", n, 15);
        expect_word(22, 8'h00, "R9 load ignored while running");
        expect_word(26, 8'h07, "R9 program result");
        drain();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule